// File: doc/BRIEF.md
# Horizontal Microcode Datapath Sequencer

This block is a small datapath run by wide, opcode-free control words held in an internal microcode store. Each 13-bit word is cut into fields, and each field drives one unit directly. The units are two operand latches, a two-cycle ALU, two result latches and a 16-entry register file. They all share a single transfer bus. Any unit whose field is non-zero acts in that cycle, so one word can, for example, keep the ALU running while it reloads an operand latch.

Fetch and decode of macro instructions happen elsewhere. A host preloads registers through a load port while the sequencer is idle. It then pulses `start` with the entry address of a micro-routine and waits for `done`. The word layout, from bit 12 down to bit 0, is:

- operand-1 load (1 bit)
- operand-2 load (1 bit)
- ALU command (3 bits: 000 idle, 001 add, 010 subtract, 011 shift left, 111 continue, any other code idle)
- result-1 drive (1 bit)
- result-2 drive (1 bit)
- register operation (2 bits: 00 idle, 01 read onto the bus, 10 write from the bus, 11 reserved)
- register index (4 bits)

The routines in the store and their entry addresses are:

| Entry | Routine |
|---|---|
| 0 | R4 = R4 + R13 |
| 6 | R2 = low half of R5 - R6 and R3 = high half; operand 1 is reloaded from R7 during the continue step |
| 13 | R10 and R11 = high and low halves of R8 << R9[4:0] |
| 20 | Deliberate bus conflict; a later step would write R15 |
| 23 | Reserved register operation on R14 while result 2 drives the bus |

Top module: `hmc_seq`

## Requirements
- R1: After reset `busy`, `done` and `err` are low and every register reads zero on `rd_data`.
- R2: When `ld_en` is high while the sequencer is idle, `ld_data` is written into register `ld_idx`. A load requested while `busy` is high is ignored.
- R3: The routine at entry 0 loads R4 and R13 into the operand latches, adds them, continues the ALU for one cycle, and writes the low half of the sum (modulo 2^16) into R4. Every field left at zero keeps its unit idle.
- R4: If more than one bus driver is active in a word (register read, result-1 drive, result-2 drive), none of that word's effects take place. The sequencer halts with `done` and `err` high, so the R15 write in the routine at entry 20 never happens.
- R5: An all-zero word halts the sequencer and raises `done` with `err` low. `done` and `err` stay as they are until the next `start`, which clears them.
- R6: The ALU samples its operands only in the cycle that starts an operation. Reloading operand 1 during the continue step (entry 6) does not change that result.
- R7: The ALU produces a 32-bit result. The high half goes to result 1 and the low half to result 2. A subtract that borrows yields 0xFFFF in the high half. Entry 13 shifts left by R9[4:0].
- R8: Register operation 11 neither drives the bus nor writes a register, so R14 keeps its value and `err` stays low (entry 23).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a routine when idle |
| entry | input | 5 | Entry address of the routine |
| ld_en | input | 1 | Host register load enable (honoured only when idle) |
| ld_idx | input | 4 | Register index for a host load |
| ld_data | input | 16 | Data for a host load |
| rd_idx | input | 4 | Register index for observation |
| rd_data | output | 16 | Contents of register `rd_idx` |
| busy | output | 1 | A routine is executing |
| done | output | 1 | The last routine halted |
| err | output | 1 | The last routine halted on a bus conflict |

## Verification
A wrong operand latch, a wrong result latch or a wrong ALU count shows up only as a wrong register value. It becomes visible on `rd_data` once the routine ends, a few cycles after `start`. The R6 reload case is chosen so that an ALU which rereads its operands after the first cycle writes a visibly different value. A microprogram counter that loses its place runs into the wrong words. It then either writes registers that should stay untouched (R12, R14, R15 are watched) or leaves `done` low until the watchdog expires. The conflict and reserved routines separate a bus arbiter that is too strict from one that is too lax, through `err` and the state of the guarded register.

// File: rtl/hmc_seq.sv
module hmc_seq #(
  parameter int DW      = 16,
  parameter int RW      = 4,
  parameter int AW      = 5,
  parameter int ALU_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] entry,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic [RW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int NREG = 1 << RW;
  localparam int UW   = 9 + RW;
  localparam int CW   = $clog2(ALU_LAT + 1);
  localparam int SW   = $clog2(2 * DW);

  localparam logic [2:0] A_ADD = 3'b001, A_SUB = 3'b010, A_SHL = 3'b011, A_CONT = 3'b111;
  localparam logic [1:0] R_RD = 2'b01, R_WR = 2'b10, R_RSV = 2'b11;

  function automatic logic [UW-1:0] w(input logic o1, input logic o2, input logic [2:0] al,
                                      input logic r1, input logic r2, input logic [1:0] rop,
                                      input int idx);
    return {o1, o2, al, r1, r2, rop, RW'(idx)};
  endfunction

  function automatic logic [UW-1:0] ucode(input logic [AW-1:0] a);
    case (a)
      5'd0:  ucode = w(1, 0, 3'b000, 0, 0, R_RD, 4);
      5'd1:  ucode = w(0, 1, 3'b000, 0, 0, R_RD, 13);
      5'd2:  ucode = w(0, 0, A_ADD,  0, 0, 2'b00, 0);
      5'd3:  ucode = w(0, 0, A_CONT, 0, 0, 2'b00, 0);
      5'd4:  ucode = w(0, 0, 3'b000, 0, 1, R_WR, 4);
      5'd6:  ucode = w(1, 0, 3'b000, 0, 0, R_RD, 5);
      5'd7:  ucode = w(0, 1, 3'b000, 0, 0, R_RD, 6);
      5'd8:  ucode = w(0, 0, A_SUB,  0, 0, 2'b00, 0);
      5'd9:  ucode = w(1, 0, A_CONT, 0, 0, R_RD, 7);
      5'd10: ucode = w(0, 0, 3'b000, 0, 1, R_WR, 2);
      5'd11: ucode = w(0, 0, 3'b000, 1, 0, R_WR, 3);
      5'd13: ucode = w(1, 0, 3'b000, 0, 0, R_RD, 8);
      5'd14: ucode = w(0, 1, 3'b000, 0, 0, R_RD, 9);
      5'd15: ucode = w(0, 0, A_SHL,  0, 0, 2'b00, 0);
      5'd16: ucode = w(0, 0, A_CONT, 0, 0, 2'b00, 0);
      5'd17: ucode = w(0, 0, 3'b000, 1, 0, R_WR, 10);
      5'd18: ucode = w(0, 0, 3'b000, 0, 1, R_WR, 11);
      5'd20: ucode = w(1, 0, 3'b000, 0, 0, R_RD, 1);
      5'd21: ucode = w(0, 1, 3'b000, 0, 1, R_RD, 0);
      5'd22: ucode = w(0, 0, 3'b000, 0, 1, R_WR, 15);
      5'd23: ucode = w(1, 0, 3'b000, 0, 0, R_RD, 1);
      5'd24: ucode = w(0, 0, 3'b000, 0, 1, R_RSV, 14);
      default: ucode = '0;
    endcase
  endfunction

  function automatic logic [2*DW-1:0] alu_f(input logic [2:0] sel, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    logic [2*DW-1:0] xa, xb;
    xa = {{DW{1'b0}}, a};
    xb = {{DW{1'b0}}, b};
    case (sel)
      A_ADD:   alu_f = xa + xb;
      A_SUB:   alu_f = xa - xb;
      A_SHL:   alu_f = xa << b[SW-1:0];
      default: alu_f = '0;
    endcase
  endfunction

  logic            run;
  logic [AW-1:0]   upc;
  logic [DW-1:0]   rf [NREG];
  logic [DW-1:0]   op1, op2, res1, res2, alu_a, alu_b;
  logic [2:0]      alu_sel;
  logic [CW-1:0]   alu_cnt;

  logic [UW-1:0]   uw;
  logic            f_o1, f_o2, f_r1, f_r2;
  logic [2:0]      f_alu;
  logic [1:0]      f_rop;
  logic [RW-1:0]   f_idx;
  logic            d_rd, conflict, alu_go, alu_fin;
  logic [DW-1:0]   bus;

  assign uw = run ? ucode(upc) : '0;
  assign {f_o1, f_o2, f_alu, f_r1, f_r2, f_rop, f_idx} = uw;
  assign d_rd     = f_rop == R_RD;
  assign conflict = (d_rd & f_r1) | (d_rd & f_r2) | (f_r1 & f_r2);
  assign bus      = d_rd ? rf[f_idx] : f_r1 ? res1 : f_r2 ? res2 : '0;
  assign alu_go   = f_alu == A_ADD || f_alu == A_SUB || f_alu == A_SHL;
  assign alu_fin  = f_alu == A_CONT && alu_cnt == CW'(1);

  assign rd_data = rf[rd_idx];
  assign busy    = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      upc  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else if (!run) begin
      if (start) begin
        run  <= 1'b1;
        upc  <= entry;
        done <= 1'b0;
        err  <= 1'b0;
      end
    end else if (conflict) begin
      run  <= 1'b0;
      done <= 1'b1;
      err  <= 1'b1;
    end else if (uw == '0) begin
      run  <= 1'b0;
      done <= 1'b1;
    end else begin
      upc <= upc + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!run) begin
      if (ld_en) rf[ld_idx] <= ld_data;
    end else if (!conflict && f_rop == R_WR) begin
      rf[f_idx] <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1     <= '0;
      op2     <= '0;
      res1    <= '0;
      res2    <= '0;
      alu_a   <= '0;
      alu_b   <= '0;
      alu_sel <= '0;
      alu_cnt <= '0;
    end else if (run && !conflict) begin
      if (f_o1) op1 <= bus;
      if (f_o2) op2 <= bus;
      if (alu_go) begin
        alu_a   <= op1;
        alu_b   <= op2;
        alu_sel <= f_alu;
        if (ALU_LAT == 1) {res1, res2} <= alu_f(f_alu, op1, op2);
        else alu_cnt <= CW'(ALU_LAT - 1);
      end else if (f_alu == A_CONT && alu_cnt != '0) begin
        alu_cnt <= alu_cnt - CW'(1);
        if (alu_fin) {res1, res2} <= alu_f(alu_sel, alu_a, alu_b);
      end
    end
  end

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  a_r2_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_en) |=> rf[$past(ld_idx)] == $past(ld_data));
  a_r4_conflict_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (run && conflict) |=> (!run && done && err));
  a_r5_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (run && uw == '0) |=> (!run && done && !err));
  a_r5_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start) |=> (run && upc == $past(entry) && !done));
  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && f_alu == A_CONT && !conflict) |=> $stable(alu_a) && $stable(alu_b));
  a_r8_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && f_rop == R_RSV) |=> rf[$past(f_idx)] == $past(rf[f_idx]));
endmodule

// File: tb/hmc_seq_tb.sv
module hmc_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, ld_en = 0;
  logic [4:0]  entry = '0;
  logic [3:0]  ld_idx = '0, rd_idx = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] rd_data;
  logic        busy, done, err;

  int n_chk = 0, n_fail = 0;
  int          q_idx[$];
  logic [15:0] q_val[$];
  string       q_tag[$];
  event        ev_run;
  bit          mon_idle = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmc_seq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .entry(entry), .ld_en(ld_en),
                 .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
                 .busy(busy), .done(done), .err(err));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_reg(input int idx, input logic [15:0] v, input string tag);
    q_idx.push_back(idx);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic load(input int idx, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1; ld_idx = 4'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic run(input int e);
    @(negedge clk);
    start = 1; entry = 5'(e);
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic drain;
    mon_idle = 0;
    -> ev_run;
    wait (mon_idle);
  endtask

  initial begin
    forever begin
      @(ev_run);
      while (q_idx.size() > 0) begin
        int i;
        i = q_idx.pop_front();
        rd_idx = 4'(i);
        #1;
        check(q_tag.pop_front(), rd_data, q_val.pop_front());
      end
      mon_idle = 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", 16'(busy), 16'h0);
    check("R1 done", 16'(done), 16'h0);
    check("R1 err", 16'(err), 16'h0);
    expect_reg(4, 16'h0000, "R1 reg4 reset");
    expect_reg(13, 16'h0000, "R1 reg13 reset");
    drain();

    load(4, 16'h1234); load(13, 16'h0F0F); load(12, 16'h00C3);
    expect_reg(12, 16'h00C3, "R2 idle load");
    drain();
    // R3 add, with an R2 load attempt while busy
    @(negedge clk); start = 1; entry = 5'd0;
    @(negedge clk); start = 0;
    check("R5 busy during run", 16'(busy), 16'h1);
    ld_en = 1; ld_idx = 4'd12; ld_data = 16'hDEAD;
    @(negedge clk); ld_en = 0;
    while (!done) @(negedge clk);
    check("R5 done after add", 16'(done), 16'h1);
    check("R5 err after add", 16'(err), 16'h0);
    expect_reg(4, 16'h2143, "R3 add R4+R13");
    expect_reg(13, 16'h0F0F, "R3 R13 untouched");
    expect_reg(12, 16'h00C3, "R2 load ignored while busy");
    drain();

    load(4, 16'hFFFF); load(13, 16'h0002);
    run(0);
    expect_reg(4, 16'h0001, "R3 add wraps low half");
    drain();

    load(5, 16'h0010); load(6, 16'h0003); load(7, 16'hAAAA);
    run(6);
    expect_reg(2, 16'h000D, "R6 sub with reload during continue");
    expect_reg(3, 16'h0000, "R7 sub high half no borrow");
    drain();

    load(5, 16'h0003); load(6, 16'h0005);
    run(6);
    expect_reg(2, 16'hFFFE, "R7 sub low half borrow");
    expect_reg(3, 16'hFFFF, "R7 sub high half borrow");
    drain();

    load(8, 16'h8001); load(9, 16'h0004);
    run(13);
    expect_reg(10, 16'h0008, "R7 shift high half");
    expect_reg(11, 16'h0010, "R7 shift low half");
    drain();

    load(15, 16'h5A5A);
    run(20);
    check("R4 err on conflict", 16'(err), 16'h1);
    check("R4 done on conflict", 16'(done), 16'h1);
    repeat (3) @(negedge clk);
    check("R4 halted stays idle", 16'(busy), 16'h0);
    expect_reg(15, 16'h5A5A, "R4 later write suppressed");
    drain();

    load(14, 16'h7777);
    run(23);
    check("R5 err cleared by start", 16'(err), 16'h0);
    check("R8 reserved no conflict", 16'(done), 16'h1);
    expect_reg(14, 16'h7777, "R8 reserved op no write");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule